// File: doc/BRIEF.md
# Banked Pixel Window Address Translator

This block turns addresses into video memory locations for a display mode that reaches a large frame store through a small, movable window. It has two independent paths. The pixel path takes a pixel column, a pixel row, the line width in pixels and the number of bytes per pixel. It returns the linear byte offset of that pixel, the 64 KB bank that holds it, and the byte position inside that bank.

The CPU path takes a 20-bit real-mode style address and the current bank selection. When the address falls inside the 64 KB window based at 0xA0000, the path returns the linear frame store address and a hit. Bank selections past the end of the 8 MB store are flagged as out of range. Both paths are registered, and each carries a valid bit that follows its input valid.

Top module: `bank_xlate`

## Requirements
- R1: The pixel byte offset `px_byte_off` equals (px_x + px_y * px_hres) * px_bpp, using full-width arithmetic with no truncation.
- R2: `px_bank` equals the byte offset divided by 65536, with the remainder dropped: offset 65535 gives bank 0 and offset 65536 gives bank 1.
- R3: `px_inbank` equals the byte offset minus px_bank * 65536. This is the low 16 bits of the offset.
- R4: `px_oor` is 1 exactly when `px_bank` is 128 or more, so that bank 127 is in range and bank 128 is not.
- R5: The pixel results and `px_out_valid` appear two clock edges after the edge that samples `px_valid`, and `px_out_valid` repeats `px_valid` with that delay.
- R6: The CPU results and `cpu_out_valid` appear one edge after sampling, and `cpu_out_valid` repeats `cpu_valid` with that delay.
- R7: For an address inside 0xA0000..0xAFFFF with a bank selection below 128, `cpu_hit` is 1, `cpu_oor` is 0, and `cpu_lin_addr` equals cpu_bank * 65536 + (cpu_addr - 0xA0000).
- R8: An address outside 0xA0000..0xAFFFF gives `cpu_hit` = 0 and `cpu_oor` = 0, whatever the bank selection is.
- R9: An address inside the window with a bank selection of 128 or more gives `cpu_oor` = 1 and `cpu_hit` = 0. The two flags are never 1 together.
- R10: After reset, `px_out_valid` and `cpu_out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | Pixel request valid |
| px_x | input | 16 | Pixel column |
| px_y | input | 16 | Pixel row |
| px_hres | input | 16 | Line width in pixels |
| px_bpp | input | 3 | Bytes per pixel |
| px_out_valid | output | 1 | Pixel result valid |
| px_byte_off | output | 36 | Linear byte offset |
| px_bank | output | 20 | Bank number |
| px_inbank | output | 16 | Byte position inside the bank |
| px_oor | output | 1 | Pixel bank beyond memory |
| cpu_valid | input | 1 | CPU request valid |
| cpu_addr | input | 20 | CPU address |
| cpu_bank | input | 16 | Current bank selection |
| cpu_out_valid | output | 1 | CPU result valid |
| cpu_hit | output | 1 | Address inside window, bank in range |
| cpu_oor | output | 1 | Address inside window, bank beyond memory |
| cpu_lin_addr | output | 32 | Linear frame store address |

## Verification
A wrong pixel offset register would show up on every field of the next pixel result, exactly two edges after the request is sampled. The row-to-bank boundary at 65536 bytes and the bank 127/128 edge show truncation and range-compare errors at once. A stale or wrongly compared CPU register would show as a wrong hit/out-of-range pair, or as wrong upper address bits, one edge after the access. Accesses one byte below and above the window catch off-by-one decode errors.

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int COORD_W   = 16,
  parameter int BPP_W     = 3,
  parameter int BANKREG_W = 16,
  parameter int MEM_BANKS = 128,
  parameter logic [19:0] WIN_BASE = 20'hA0000,
  localparam int OFF_W  = 2*COORD_W + BPP_W + 1,
  localparam int BANK_W = OFF_W - 16,
  localparam int LIN_W  = BANKREG_W + 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               px_valid,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [COORD_W-1:0] px_hres,
  input  logic [BPP_W-1:0]   px_bpp,
  output logic               px_out_valid,
  output logic [OFF_W-1:0]   px_byte_off,
  output logic [BANK_W-1:0]  px_bank,
  output logic [15:0]        px_inbank,
  output logic               px_oor,
  input  logic               cpu_valid,
  input  logic [19:0]        cpu_addr,
  input  logic [BANKREG_W-1:0] cpu_bank,
  output logic               cpu_out_valid,
  output logic               cpu_hit,
  output logic               cpu_oor,
  output logic [LIN_W-1:0]   cpu_lin_addr
);

  logic             v1_q;
  logic [OFF_W-1:0] off1_q;
  logic [OFF_W-1:0] pix_lin;

  assign pix_lin = OFF_W'(px_y) * OFF_W'(px_hres) + OFF_W'(px_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q         <= 1'b0;
      px_out_valid <= 1'b0;
    end else begin
      v1_q         <= px_valid;
      px_out_valid <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (px_valid) off1_q <= pix_lin * OFF_W'(px_bpp);
    if (v1_q) begin
      px_byte_off <= off1_q;
      px_bank     <= off1_q[OFF_W-1:16];
      px_inbank   <= off1_q[15:0];
      px_oor      <= off1_q[OFF_W-1:16] >= BANK_W'(MEM_BANKS);
    end
  end

  logic in_win, bank_big;
  assign in_win   = cpu_addr[19:16] == WIN_BASE[19:16];
  assign bank_big = cpu_bank >= BANKREG_W'(MEM_BANKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_out_valid <= 1'b0;
      cpu_hit       <= 1'b0;
      cpu_oor       <= 1'b0;
    end else begin
      cpu_out_valid <= cpu_valid;
      if (cpu_valid) begin
        cpu_hit <= in_win && !bank_big;
        cpu_oor <= in_win && bank_big;
      end
    end
  end

  always_ff @(posedge clk)
    if (cpu_valid) cpu_lin_addr <= {cpu_bank, cpu_addr[15:0]};

endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int COORD_W   = 16,
  parameter int BPP_W     = 3,
  parameter int BANKREG_W = 16,
  parameter int MEM_BANKS = 128,
  localparam int OFF_W  = 2*COORD_W + BPP_W + 1,
  localparam int BANK_W = OFF_W - 16,
  localparam int LIN_W  = BANKREG_W + 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               px_valid,
  input logic               px_out_valid,
  input logic [OFF_W-1:0]   px_byte_off,
  input logic [BANK_W-1:0]  px_bank,
  input logic [15:0]        px_inbank,
  input logic               px_oor,
  input logic               cpu_valid,
  input logic [19:0]        cpu_addr,
  input logic               cpu_out_valid,
  input logic               cpu_hit,
  input logic               cpu_oor,
  input logic [LIN_W-1:0]   cpu_lin_addr
);
  logic [1:0] cyc;
  always_ff @(posedge clk)
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!px_out_valid && !cpu_out_valid));
  a_r5_px_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    cyc >= 2'd2 |-> px_out_valid == $past(px_valid, 2));
  a_r6_cpu_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    cyc >= 2'd1 |-> cpu_out_valid == $past(cpu_valid));
  a_r3_inbank_low: assert property (@(posedge clk) disable iff (!rst_n)
    px_out_valid |-> px_inbank == px_byte_off[15:0]);
  a_r2_bank_split: assert property (@(posedge clk) disable iff (!rst_n)
    px_out_valid |-> {px_bank, px_inbank} == px_byte_off);
  a_r4_px_range: assert property (@(posedge clk) disable iff (!rst_n)
    px_out_valid |-> px_oor == (px_bank >= BANK_W'(MEM_BANKS)));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_out_valid |-> !(cpu_hit && cpu_oor));
  a_r7_low_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && cpu_out_valid && cpu_hit) |-> cpu_lin_addr[15:0] == $past(cpu_addr[15:0]));
endmodule

bind bank_xlate bank_xlate_chk #(
  .COORD_W(COORD_W), .BPP_W(BPP_W), .BANKREG_W(BANKREG_W), .MEM_BANKS(MEM_BANKS)
) chk_i (.*);

// File: tb/bank_xlate_tb.sv
module bank_xlate_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic px_valid = 0, cpu_valid = 0;
  logic [15:0] px_x = 0, px_y = 0, px_hres = 0, cpu_bank = 0;
  logic [2:0]  px_bpp = 0;
  logic [19:0] cpu_addr = 0;
  logic px_out_valid, px_oor, cpu_out_valid, cpu_hit, cpu_oor;
  logic [35:0] px_byte_off;
  logic [19:0] px_bank;
  logic [15:0] px_inbank;
  logic [31:0] cpu_lin_addr;

  int n_cmp = 0, n_bad = 0;

  bank_xlate dut_i (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pix_case(input int x, input int y, input int h, input int b);
    longint off;
    off = (longint'(y) * h + x) * b;
    @(negedge clk);
    px_x = 16'(x); px_y = 16'(y); px_hres = 16'(h); px_bpp = 3'(b); px_valid = 1;
    @(negedge clk);
    px_valid = 0;
    chk("R5 not yet valid", px_out_valid, 0);
    @(negedge clk);
    chk("R5 valid", px_out_valid, 1);
    chk("R1 offset", px_byte_off, off);
    chk("R2 bank", px_bank, off / 65536);
    chk("R3 inbank", px_inbank, off - (off / 65536) * 65536);
    chk("R4 oor", px_oor, (off / 65536) >= 128);
    @(negedge clk);
    chk("R5 drop", px_out_valid, 0);
  endtask

  task automatic cpu_case(input int a, input int bk);
    bit inw;
    inw = (a >= 'hA0000) && (a <= 'hAFFFF);
    @(negedge clk);
    cpu_addr = 20'(a); cpu_bank = 16'(bk); cpu_valid = 1;
    @(negedge clk);
    cpu_valid = 0;
    chk("R6 valid", cpu_out_valid, 1);
    if (!inw) begin
      chk("R8 hit outside", cpu_hit, 0);
      chk("R8 oor outside", cpu_oor, 0);
    end else if (bk >= 128) begin
      chk("R9 oor", cpu_oor, 1);
      chk("R9 hit", cpu_hit, 0);
    end else begin
      chk("R7 hit", cpu_hit, 1);
      chk("R7 oor", cpu_oor, 0);
      chk("R7 lin", cpu_lin_addr, longint'(bk) * 65536 + (a - 'hA0000));
    end
    @(negedge clk);
    chk("R6 drop", cpu_out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 px valid reset", px_out_valid, 0);
    chk("R10 cpu valid reset", cpu_out_valid, 0);
    rst_n = 1;
    pix_case(10, 20, 640, 1);
    pix_case(0, 200, 800, 2);
    pix_case(65535, 0, 1024, 1);
    pix_case(0, 64, 1024, 1);
    pix_case(1023, 767, 1024, 4);
    pix_case(1023, 2047, 1024, 4);
    pix_case(0, 2048, 1024, 4);
    pix_case(65535, 65535, 65535, 4);
    pix_case(7, 9, 320, 3);
    cpu_case('hA0000, 0);
    cpu_case('hAFFFF, 5);
    cpu_case('hA1234, 127);
    cpu_case('hA1234, 128);
    cpu_case('hA0000, 65535);
    cpu_case('h9FFFF, 3);
    cpu_case('hB0000, 3);
    cpu_case('h12345, 200);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule